// File: doc/BRIEF.md
# Two-Wire Converter Result Reader

This block is the host-side master for a serial converter whose chip select is tied low, so only two wires remain: a serial clock driven by this block (`sck`) and a data line driven by the converter (`sdo`). On a `start` request the reader waits until the converter has a result. It then drives a burst of SCK pulses, shifts in a 16-bit two's-complement result MSB first, and presents that result with a one-cycle `result_valid` strobe. It finishes the frame with the SCK edge that tells the converter to begin its next conversion.

The `IDLE_HIGH` parameter sets the SCK resting level, and that level also sets how the end of conversion is detected. With SCK resting high, the converter pulls SDO low when a result is ready. The reader waits for that low level and issues 17 pulses: 16 for data and one trailing pulse that restarts the converter. With SCK resting low, SDO carries no status. The reader then counts `CONV_WAIT` clock cycles from the previous restart edge (or from reset) and issues exactly 16 pulses. The falling edge of the last of these restarts the converter. `HALF_DIV` sets how many system clock cycles each SCK level lasts.

Top module: `adc2w_reader`

## Requirements
- R1: While reset is asserted and right after it, `sck` is at the idle level (1 when `IDLE_HIGH`=1, else 0), `busy` and `result_valid` are 0, and `result` is 0.
- R2: A `start` seen in a cycle while `busy` is 0 makes `busy` 1 from the next cycle. A `start` seen while `busy` is 1 has no effect: the frame runs out as if it had not occurred, and no further frame follows.
- R3: With `IDLE_HIGH`=1, after a start SCK stays high for as long as SDO is high. The reader enters the clocking phase in the cycle after SDO has been sampled low at two consecutive clock edges. The first SCK edge comes `HALF_DIV` cycles after that.
- R4: With `IDLE_HIGH`=0, the reader enters the clocking phase only after its wait counter has run `CONV_WAIT` cycles. The counter restarts at reset release and at the last SCK edge of every frame. If the count has already expired, clocking follows straight after the one wait cycle.
- R5: Every SCK level inside a frame lasts exactly `HALF_DIV` clock cycles. An idle-high frame has 17 pulses and begins with a falling edge. An idle-low frame has 16 pulses and begins with a rising edge. Outside a frame, SCK rests at the idle level.
- R6: SDO is sampled at the clock edge where SCK rises, on the first 16 rising edges of a frame. The first sample becomes `result[15]` (the sign) and the sixteenth becomes `result[0]`.
- R7: `result_valid` is high for exactly one cycle, in the cycle right after the sixteenth sample. `result` changes only together with that strobe and holds its value in between.
- R8: `busy` stays 1 through the whole frame and falls in the cycle after the last SCK edge. That edge is the rising edge of pulse 17 when idle-high, and the falling edge of pulse 16 when idle-low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to read one result |
| sdo | input | 1 | Serial data and ready flag from the converter |
| sck | output | 1 | Serial clock to the converter |
| busy | output | 1 | High from an accepted start to the end of the frame |
| result | output | DATA_W | Last assembled result, MSB is the sign |
| result_valid | output | 1 | One-cycle strobe when `result` is updated |

## Verification
The in-line properties assume that the converter changes SDO only after a falling SCK edge, so that SDO is stable where the reader samples it. They also assume that in idle-low mode the real conversion time is shorter than `CONV_WAIT`, so a timer-started frame never reads a stale word. The bench's converter model keeps to both assumptions. It updates SDO half a clock after it sees SCK fall, and its conversion time is set below the timer length in the idle-low lane, while in the idle-high lane it is long enough that a start arrives during a conversion. Start pulses are sent both while idle and in the middle of a frame, with gaps that land before and after the converter becomes ready.

// File: rtl/adc2w_pkg.sv
package adc2w_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_RUN  = 2'd2
   } adc2w_state_e;

   // Pulses in one frame: the data bits plus, when SCK rests high, one restart pulse
   function automatic int pulses_per_frame(input int data_w, input bit idle_high);
      return idle_high ? data_w + 1 : data_w;
   endfunction

endpackage

// File: rtl/adc2w_sck_gen.sv
module adc2w_sck_gen #(
   parameter int HALF_DIV = 4,
   parameter int EDGES    = 34,
   parameter bit IDLE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sck,
   output logic rise_tick,
   output logic last_tick
);

   localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam int EW = $clog2(EDGES + 1);

   logic [HW-1:0] hcnt;
   logic [EW-1:0] ecnt;
   logic          sck_q;
   logic          tick;

   assign tick      = run && (hcnt == HW'(HALF_DIV - 1));
   assign rise_tick = tick && !sck_q;
   assign last_tick = tick && (ecnt == EW'(EDGES - 1));
   assign sck       = sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hcnt  <= '0;
         ecnt  <= '0;
         sck_q <= IDLE_LVL;
      end else if (!run) begin
         hcnt  <= '0;
         ecnt  <= '0;
         sck_q <= IDLE_LVL;
      end else if (tick) begin
         hcnt  <= '0;
         ecnt  <= ecnt + 1'b1;
         sck_q <= ~sck_q;
      end else begin
         hcnt  <= hcnt + 1'b1;
      end
   end

   AST_EDGE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (ecnt < EW'(EDGES))); // R5

endmodule

// File: rtl/adc2w_eoc.sv
module adc2w_eoc #(
   parameter bit IDLE_HIGH = 1'b1,
   parameter int CONV_WAIT = 600
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sdo,
   input  logic frame_end,
   output logic ready
);

   generate
      if (IDLE_HIGH) begin : g_flag
         // Ready flag is SDO low, taken on two consecutive samples
         logic sdo_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         sdo_q <= 1'b1;
            else if (frame_end) sdo_q <= 1'b1;
            else                sdo_q <= sdo;
         end
         assign ready = ~sdo & ~sdo_q;
      end else begin : g_timer
         localparam int TW = $clog2(CONV_WAIT + 1);
         logic [TW-1:0] wait_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          wait_cnt <= '0;
            else if (frame_end)                  wait_cnt <= '0;
            else if (wait_cnt != TW'(CONV_WAIT)) wait_cnt <= wait_cnt + 1'b1;
         end
         assign ready = (wait_cnt == TW'(CONV_WAIT));
      end
   endgenerate

endmodule

// File: rtl/adc2w_shifter.sv
module adc2w_shifter #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              take,
   input  logic              sdo,
   output logic [DATA_W-1:0] data,
   output logic              valid
);

   localparam int CW = $clog2(DATA_W + 1);

   logic [DATA_W-2:0] sh;
   logic [CW-1:0]     cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh    <= '0;
         cnt   <= '0;
         data  <= '0;
         valid <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (!run) begin
            cnt <= '0;
         end else if (take && (cnt < CW'(DATA_W))) begin
            sh  <= {sh[DATA_W-3:0], sdo};
            cnt <= cnt + 1'b1;
            if (cnt == CW'(DATA_W - 1)) begin
               data  <= {sh, sdo};
               valid <= 1'b1;
            end
         end
      end
   end

   AST_CAPTURE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (cnt == CW'(DATA_W))); // R6

endmodule

// File: rtl/adc2w_reader.sv
module adc2w_reader
   import adc2w_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int HALF_DIV  = 4,
   parameter bit IDLE_HIGH = 1'b1,
   parameter int CONV_WAIT = 600
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              sdo,
   output logic              sck,
   output logic              busy,
   output logic [DATA_W-1:0] result,
   output logic              result_valid
);

   localparam int   PULSES   = pulses_per_frame(DATA_W, IDLE_HIGH);
   localparam int   EDGES    = 2 * PULSES;
   localparam logic IDLE_LVL = IDLE_HIGH;

   generate
      if (DATA_W < 4)   begin : g_bad_width $error("DATA_W must be at least 4");   end
      if (HALF_DIV < 1) begin : g_bad_div   $error("HALF_DIV must be at least 1"); end
      if (!IDLE_HIGH && CONV_WAIT < 1) begin : g_bad_wait
         $error("CONV_WAIT must be at least 1 in idle-low mode");
      end
   endgenerate

   adc2w_state_e state;
   logic         run;
   logic         ready;
   logic         rise_tick;
   logic         last_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
      end else begin
         unique case (state)
            ST_IDLE: if (start)     state <= ST_WAIT;
            ST_WAIT: if (ready)     state <= ST_RUN;
            ST_RUN:  if (last_tick) state <= ST_IDLE;
            default:                state <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state != ST_IDLE);
   assign run  = (state == ST_RUN);

   adc2w_eoc #(
      .IDLE_HIGH (IDLE_HIGH),
      .CONV_WAIT (CONV_WAIT)
   ) u_eoc (
      .clk       (clk),
      .rst_n     (rst_n),
      .sdo       (sdo),
      .frame_end (last_tick),
      .ready     (ready)
   );

   adc2w_sck_gen #(
      .HALF_DIV (HALF_DIV),
      .EDGES    (EDGES),
      .IDLE_LVL (IDLE_LVL)
   ) u_sck_gen (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .sck       (sck),
      .rise_tick (rise_tick),
      .last_tick (last_tick)
   );

   adc2w_shifter #(
      .DATA_W (DATA_W)
   ) u_shifter (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .take  (rise_tick),
      .sdo   (sdo),
      .data  (result),
      .valid (result_valid)
   );

   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid); // R7
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> result_valid); // R7
   AST_SCK_REST: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sck == IDLE_LVL)); // R5
   AST_VALID_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> busy); // R8

   generate
      if (IDLE_HIGH) begin : g_chk_flag
         AST_HOLD_FOR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            (state == ST_WAIT && sdo) |=> (state == ST_WAIT && sck == IDLE_LVL)); // R3
      end else begin : g_chk_timer
         AST_HOLD_FOR_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
            (state == ST_WAIT) |=> (sck == IDLE_LVL)); // R4
      end
   endgenerate

endmodule

// File: tb/adc2w_reader_bench.sv
module adc2w_reader_lane #(
   parameter bit IH   = 1'b1,
   parameter int D    = 4,
   parameter int CW   = 300,
   parameter int DEVC = 150,
   parameter int SEED = 0
) (
   input  logic clk,
   input  logic rst_n,
   output logic done
);

   localparam logic IDLE  = IH;
   localparam int   EDGES = IH ? 34 : 32;
   localparam int   VK    = IH ? 32 : 31;
   localparam int   NF    = 6;

   logic        start;
   logic        sdo;
   logic        sck;
   logic        busy;
   logic        valid;
   logic [15:0] result;

   adc2w_reader #(
      .DATA_W    (16),
      .HALF_DIV  (D),
      .IDLE_HIGH (IH),
      .CONV_WAIT (CW)
   ) u_adc2w_reader (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .sdo          (sdo),
      .sck          (sck),
      .busy         (busy),
      .result       (result),
      .result_valid (valid)
   );

   integer n_chk  = 0;
   integer n_fail = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_chk = n_chk + 1;
      if (!ok) begin
         n_fail = n_fail + 1;
         $display("FAIL %s %s (%s lane): act=%0h exp=%0h",
                  tag, what, IH ? "idle-high" : "idle-low", act, exp);
      end
   endtask

   function automatic logic [15:0] dev_word(input int i);
      case (i)
         0:       return 16'h8000;
         1:       return 16'h7FFF;
         2:       return 16'hFFFF;
         3:       return 16'h0000;
         default: return 16'((32'hA5C3 + SEED * 32'h0F0F) ^ (i * 32'h1357));
      endcase
   endfunction

   // Behavioural reference: frame phase counted in clock cycles
   int   m_state;
   int   m_n;
   int   m_t;
   bit   m_sdoq;
   bit   m_ign;
   logic e_sck;
   logic e_busy;
   logic e_valid;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0;
         m_n     = 0;
         m_t     = 0;
         m_sdoq  = 1'b1;
         m_ign   = 1'b0;
      end else begin
         bit fin;
         fin = 1'b0;
         case (m_state)
            0: if (start) begin m_state = 1; m_ign = 1'b0; end
            1: begin
               if (IH ? (!sdo && !m_sdoq) : (m_t >= CW)) begin
                  m_state = 2;
                  m_n     = 0;
               end
               if (start) m_ign = 1'b1;
            end
            default: begin
               m_n = m_n + 1;
               if (start) m_ign = 1'b1;
               if (m_n == EDGES * D) begin
                  m_state = 0;
                  fin     = 1'b1;
               end
            end
         endcase
         m_sdoq = fin ? 1'b1 : sdo;
         if (fin)         m_t = 0;
         else if (m_t < CW) m_t = m_t + 1;
      end
      e_busy  = (m_state != 0);
      e_sck   = (m_state == 2) ? (IDLE ^ (((m_n / D) % 2) == 1)) : IDLE;
      e_valid = (m_state == 2) && (m_n == VK * D);
   end

   // Converter model and per-cycle comparison, both away from the active edge
   logic [15:0] expq[$];
   logic [15:0] word;
   logic [15:0] last_res;
   int          widx;
   int          dconv;
   int          fcnt;
   logic        psck;

   always @(negedge clk) begin
      if (!rst_n) begin
         widx = 0;
         word = dev_word(0);
         expq.delete();
         expq.push_back(word);
         dconv    = DEVC;
         fcnt     = 0;
         psck     = IDLE;
         sdo      = 1'b1;
         last_res = '0;
         chk(sck == IDLE, "R1", "sck in reset", int'(sck), int'(IDLE));
         chk(!busy, "R1", "busy in reset", int'(busy), 0);
         chk(!valid, "R1", "valid in reset", int'(valid), 0);
         chk(result == 16'h0, "R1", "result in reset", int'(result), 0);
      end else begin
         bit    fall;
         string stag;
         string btag;
         stag = (m_state == 1) ? (IH ? "R3" : "R4") : "R5";
         btag = ((m_state == 1) || (m_state == 0 && m_ign)) ? "R2" : "R8";
         chk(sck == e_sck, stag, "sck level", int'(sck), int'(e_sck));
         chk(busy == e_busy, btag, "busy", int'(busy), int'(e_busy));
         chk(valid == e_valid, "R7", "valid strobe", int'(valid), int'(e_valid));
         if (e_valid) begin
            logic [15:0] exp_w;
            exp_w = (expq.size() > 0) ? expq.pop_front() : 16'hDEAD;
            chk(result == exp_w, "R6", "assembled result", int'(result), int'(exp_w));
            last_res = exp_w;
         end else begin
            chk(result == last_res, "R7", "result hold", int'(result), int'(last_res));
         end

         fall = psck && !sck;
         psck = sck;
         if (dconv > 0) begin
            dconv = dconv - 1;
            if (dconv == 0) begin
               fcnt = 0;
               sdo  = IH ? 1'b0 : word[15];
            end
         end else if (fall) begin
            fcnt = fcnt + 1;
            if (fcnt < (IH ? 17 : 16)) begin
               sdo = IH ? word[16 - fcnt] : word[15 - fcnt];
            end else begin
               widx  = widx + 1;
               word  = dev_word(widx);
               expq.push_back(word);
               dconv = DEVC;
               sdo   = 1'b1;
            end
         end
      end
   end

   // Stimulus: gaps before start land both before and after the converter is ready
   initial begin
      int gaps[NF];
      gaps  = '{3, 200, 1, 60, 400, 9};
      done  = 1'b0;
      start = 1'b0;
      @(posedge rst_n);
      for (int f = 0; f < NF; f++) begin
         repeat (gaps[f]) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         if (f % 2 == 1) begin
            repeat (20) @(negedge clk);
            start = 1'b1;           // R2: arrives while busy, must be ignored
            @(negedge clk);
            start = 1'b0;
         end
         while (busy) @(negedge clk);
      end
      repeat (30) @(negedge clk);   // R2: no extra frame after the ignored start
      done = 1'b1;
   end

endmodule

module adc2w_reader_bench;

   logic clk   = 1'b0;
   logic rst_n = 1'b0;
   logic done_hi;
   logic done_lo;

   always #5 clk = ~clk;

   adc2w_reader_lane #(.IH(1'b1), .D(4), .CW(300), .DEVC(150), .SEED(1)) u_lane_hi (
      .clk   (clk),
      .rst_n (rst_n),
      .done  (done_hi)
   );

   adc2w_reader_lane #(.IH(1'b0), .D(3), .CW(300), .DEVC(250), .SEED(2)) u_lane_lo (
      .clk   (clk),
      .rst_n (rst_n),
      .done  (done_lo)
   );

   initial begin
      int cyc;
      int total;
      int fails;
      cyc = 0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      while (!(done_hi === 1'b1 && done_lo === 1'b1) && cyc < 150000) begin
         @(negedge clk);
         cyc++;
      end
      total = u_lane_hi.n_chk + u_lane_lo.n_chk;
      fails = u_lane_hi.n_fail + u_lane_lo.n_fail;
      if (cyc >= 150000) begin
         total++;
         fails++;
         $display("FAIL R8 watchdog expired: act=%0d exp<%0d cycles", cyc, 150000);
      end
      $display("[TB] %0d tests run, %0d failed", total, fails);
      $finish;
   end

endmodule